// File: doc/BRIEF.md
# Packet CRC Inserter and Checker

This block sits between user logic and a line encoder on a byte stream in which every symbol is a byte plus a flag that marks it as a control character. Packets open with a start control symbol and close with an end control symbol.

On the transmit side the block forwards the stream. It keeps a CRC-32 over the bytes between the delimiters. When the end symbol arrives, the block holds that symbol back and stalls the source. It emits the four CRC bytes first and then releases the end symbol, so the packet grows by exactly four bytes.

On the receive side the block watches a stream of the same kind. After each closed packet it pulses a pass or a fail flag. The fail flag means the last four bytes before the end symbol do not match the CRC of the bytes ahead of them. Both paths handle one lane only.

Top module: `pkt_crc_engine`

## Requirements
- R1: A start symbol (K flag 1, byte 0xFB) opens a packet and presets the transmit CRC to all ones. The symbol itself passes to the output unchanged.
- R2: Every symbol that the source delivers reaches the transmit output in order, with its byte and K flag unchanged. This includes control characters inside a packet.
- R3: When an end symbol (K flag 1, byte 0xFD) closes an open packet, four CRC bytes with K flag 0 go out just before it. The CRC is CRC-32 with polynomial 0x04C11DB7, processed most significant bit first, preset to all ones and inverted at the end. It covers every byte strictly between the delimiters and is sent most significant byte first.
- R4: While the four CRC bytes are presented, tx_in_ready stays low. With the output always ready, the end symbol waits exactly four cycles before it is accepted.
- R5: While tx_out_valid is high and tx_out_ready is low, the transmit output symbol holds steady until it is taken.
- R6: An end symbol that arrives with no open packet passes through alone, with no CRC bytes added.
- R7: A start symbol inside an open packet restarts the transmit CRC. Only the bytes after the last start symbol are covered.
- R8: One cycle after the receiver accepts an end symbol that closes an open packet, exactly one of rx_crc_ok and rx_crc_err pulses high for one cycle. rx_crc_ok means the four bytes before the end symbol equal the CRC (as in R3) of the bytes before those four.
- R9: A received packet with fewer than four bytes between its delimiters flags rx_crc_err. An end symbol with no open packet raises no flag.
- R10: A start symbol inside an open received packet restarts the check from that point.
- R11: rx_crc_ok and rx_crc_err are never high together, and both stay low in every cycle that does not follow a closing end symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_in_valid | input | 1 | Source symbol valid |
| tx_in_ready | output | 1 | Block accepts the source symbol |
| tx_in_data | input | 8 | Source symbol byte |
| tx_in_k | input | 1 | Source symbol is a control character |
| tx_out_valid | output | 1 | Output symbol valid |
| tx_out_ready | input | 1 | Encoder accepts the output symbol |
| tx_out_data | output | 8 | Output symbol byte |
| tx_out_k | output | 1 | Output symbol is a control character |
| rx_valid | input | 1 | Received symbol valid |
| rx_data | input | 8 | Received symbol byte |
| rx_k | input | 1 | Received symbol is a control character |
| rx_crc_ok | output | 1 | Pulse: closed packet passed its check |
| rx_crc_err | output | 1 | Pulse: closed packet failed its check |

## Verification
The assertions check several rules on every cycle:
- the source is stalled during insertion;
- the output stays stable under backpressure;
- the tail state is reached only through insertion;
- a receive flag appears only after a closing end symbol;
- the flags are mutually exclusive;
- a short packet is flagged as an error.

Only the bench scenarios can show that the inserted bytes carry the right CRC value in the right byte order. The bench covers every payload length from 0 to 40, with and without random backpressure, looped back into the receiver. It also covers the stray end symbol, the restart on a repeated start symbol, and receive-side corruption of both payload and CRC bytes.

// File: rtl/pkt_crc_pkg.sv
package pkt_crc_pkg;

    localparam int unsigned SYM_BITS  = 8;
    localparam int unsigned CRC_BITS  = 32;
    localparam int unsigned CRC_BYTES = CRC_BITS / SYM_BITS;
    localparam logic [SYM_BITS-1:0] SOP_CODE = 8'hFB;
    localparam logic [SYM_BITS-1:0] EOP_CODE = 8'hFD;
    localparam logic [CRC_BITS-1:0] CRC_PRESET = '1;

    typedef struct packed {
        logic                k;
        logic [SYM_BITS-1:0] d;
    } sym_t;

    typedef enum logic [1:0] {
        TX_PASS = 2'd0,
        TX_INS  = 2'd1,
        TX_TAIL = 2'd2
    } tx_st_e;

    function automatic logic is_sop(sym_t s);
        return s.k && (s.d == SOP_CODE);
    endfunction

    function automatic logic is_eop(sym_t s);
        return s.k && (s.d == EOP_CODE);
    endfunction

    // one byte through the CRC register, most significant bit first
    function automatic logic [CRC_BITS-1:0] crc_step(logic [CRC_BITS-1:0] c,
                                                     logic [SYM_BITS-1:0] b,
                                                     logic [CRC_BITS-1:0] poly);
        logic [CRC_BITS-1:0] r;
        logic                fb;
        r = c;
        for (int i = SYM_BITS - 1; i >= 0; i--) begin
            fb = r[CRC_BITS-1] ^ b[i];
            r  = {r[CRC_BITS-2:0], 1'b0};
            if (fb) r = r ^ poly;
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_tx_insert.sv
module crc_tx_insert
    import pkt_crc_pkg::*;
#(
    parameter logic [CRC_BITS-1:0] POLY = 32'h04C11DB7
) (
    input  logic clk,
    input  logic rst,
    input  logic s_valid,
    output logic s_ready,
    input  sym_t s_sym,
    output logic m_valid,
    input  logic m_ready,
    output sym_t m_sym
);
    localparam int unsigned IDX_W = $clog2(CRC_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CRC_BYTES - 1);

    tx_st_e              st;
    logic [IDX_W-1:0]    idx;
    logic                open_q;
    logic [CRC_BITS-1:0] crc_q;

    logic                ins;
    logic [IDX_W-1:0]    sel;
    logic [CRC_BITS-1:0] fin;
    logic [SYM_BITS-1:0] crc_byte;
    logic                in_hs;
    logic                out_hs;

    always_comb begin
        ins = (st == TX_INS) || (st == TX_PASS && open_q && s_valid && is_eop(s_sym));
        sel = (st == TX_PASS) ? '0 : idx;
        fin = ~crc_q;
        crc_byte = '0;
        for (int b = 0; b < CRC_BYTES; b++) begin
            if (sel == IDX_W'(b))
                crc_byte = fin[CRC_BITS-1-SYM_BITS*b -: SYM_BITS];
        end
        if (ins) begin
            m_valid = 1'b1;
            m_sym   = '{k: 1'b0, d: crc_byte};
            s_ready = 1'b0;
        end else begin
            m_valid = s_valid;
            m_sym   = s_sym;
            s_ready = m_ready;
        end
        in_hs  = s_valid && s_ready;
        out_hs = m_valid && m_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= TX_PASS;
            idx    <= '0;
            open_q <= 1'b0;
            crc_q  <= CRC_PRESET;
        end else begin
            case (st)
                TX_PASS: begin
                    if (ins && out_hs) begin
                        st  <= TX_INS;
                        idx <= IDX_W'(1);
                    end else if (in_hs) begin
                        if (is_sop(s_sym)) begin
                            open_q <= 1'b1;
                            crc_q  <= CRC_PRESET;
                        end else if (open_q && !is_eop(s_sym)) begin
                            crc_q <= crc_step(crc_q, s_sym.d, POLY);
                        end
                    end
                end
                TX_INS: begin
                    if (out_hs) begin
                        if (idx == LAST_IDX) st <= TX_TAIL;
                        else                 idx <= idx + 1'b1;
                    end
                end
                TX_TAIL: begin
                    if (in_hs) begin
                        open_q <= 1'b0;
                        idx    <= '0;
                        st     <= TX_PASS;
                    end
                end
                default: st <= TX_PASS;
            endcase
        end
    end

    // R4: source is stalled while CRC bytes are presented
    p_stall_insert_r4: assert property (@(posedge clk) disable iff (rst)
        (st == TX_INS) |-> !s_ready);

    // R4: the held end symbol is released only after the insertion state
    p_tail_after_ins_r4: assert property (@(posedge clk) disable iff (rst)
        (st == TX_TAIL) |-> ($past(st) != TX_PASS));

    // R5: an inserted byte holds under backpressure
    p_hold_backpressure_r5: assert property (@(posedge clk) disable iff (rst)
        (st == TX_INS && m_valid && !m_ready) |=> (m_valid && $stable(m_sym)));

endmodule

// File: rtl/crc_rx_check.sv
module crc_rx_check
    import pkt_crc_pkg::*;
#(
    parameter logic [CRC_BITS-1:0] POLY = 32'h04C11DB7
) (
    input  logic clk,
    input  logic rst,
    input  logic r_valid,
    input  sym_t r_sym,
    output logic ok,
    output logic err
);
    localparam int unsigned FILL_W = $clog2(CRC_BYTES + 1);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(CRC_BYTES);

    logic                open_q;
    logic [FILL_W-1:0]   fill;
    logic [CRC_BITS-1:0] win;
    logic [CRC_BITS-1:0] crc_q;
    logic                match;

    assign match = (fill == FULL) && (win == ~crc_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            fill   <= '0;
            win    <= '0;
            crc_q  <= CRC_PRESET;
            ok     <= 1'b0;
            err    <= 1'b0;
        end else begin
            ok  <= 1'b0;
            err <= 1'b0;
            if (r_valid) begin
                if (is_sop(r_sym)) begin
                    open_q <= 1'b1;
                    fill   <= '0;
                    crc_q  <= CRC_PRESET;
                end else if (is_eop(r_sym)) begin
                    if (open_q) begin
                        ok     <= match;
                        err    <= !match;
                        open_q <= 1'b0;
                    end
                end else if (open_q) begin
                    win <= {win[CRC_BITS-SYM_BITS-1:0], r_sym.d};
                    if (fill == FULL) crc_q <= crc_step(crc_q, win[CRC_BITS-1 -: SYM_BITS], POLY);
                    else              fill  <= fill + 1'b1;
                end
            end
        end
    end

    // R11: at most one verdict per cycle
    p_one_verdict_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ok, err}));

    // R8: a verdict follows only a closing end symbol
    p_verdict_cause_r8: assert property (@(posedge clk) disable iff (rst)
        (ok || err) |-> $past(r_valid && is_eop(r_sym) && open_q));

    // R9: too short to hold a CRC means error
    p_short_err_r9: assert property (@(posedge clk) disable iff (rst)
        (r_valid && is_eop(r_sym) && open_q && fill != FULL) |=> err);

endmodule

// File: rtl/pkt_crc_engine.sv
module pkt_crc_engine
    import pkt_crc_pkg::*;
#(
    parameter logic [31:0] POLY = 32'h04C11DB7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_in_valid,
    output logic       tx_in_ready,
    input  logic [7:0] tx_in_data,
    input  logic       tx_in_k,
    output logic       tx_out_valid,
    input  logic       tx_out_ready,
    output logic [7:0] tx_out_data,
    output logic       tx_out_k,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_k,
    output logic       rx_crc_ok,
    output logic       rx_crc_err
);
    sym_t tx_in_sym;
    sym_t tx_out_sym;
    sym_t rx_sym;

    assign tx_in_sym   = '{k: tx_in_k, d: tx_in_data};
    assign rx_sym      = '{k: rx_k, d: rx_data};
    assign tx_out_data = tx_out_sym.d;
    assign tx_out_k    = tx_out_sym.k;

    crc_tx_insert #(.POLY(POLY)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .s_valid (tx_in_valid),
        .s_ready (tx_in_ready),
        .s_sym   (tx_in_sym),
        .m_valid (tx_out_valid),
        .m_ready (tx_out_ready),
        .m_sym   (tx_out_sym)
    );

    crc_rx_check #(.POLY(POLY)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .r_valid (rx_valid),
        .r_sym   (rx_sym),
        .ok      (rx_crc_ok),
        .err     (rx_crc_err)
    );

endmodule

// File: tb/sim_pkt_crc_engine.sv
module sim_pkt_crc_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_in_valid = 1'b0;
    logic       tx_in_ready;
    logic [7:0] tx_in_data = '0;
    logic       tx_in_k = 1'b0;
    logic       tx_out_valid;
    logic       tx_out_ready = 1'b1;
    logic [7:0] tx_out_data;
    logic       tx_out_k;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_k;
    logic       rx_crc_ok;
    logic       rx_crc_err;

    logic       inj = 1'b0;
    logic       b_valid = 1'b0;
    logic [7:0] b_data = '0;
    logic       b_k = 1'b0;
    logic       rnd = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    int checks = 0;
    int fails = 0;
    int ok_cnt = 0;
    int err_cnt = 0;
    int both_cnt = 0;
    int stall_viol = 0;
    int exp_n = 0;
    int got_n = 0;
    logic [8:0] exp_mem [0:2047];
    logic [8:0] got_mem [0:2047];

    always #4 clk = ~clk;

    assign rx_valid = inj ? b_valid : (tx_out_valid && tx_out_ready);
    assign rx_data  = inj ? b_data  : tx_out_data;
    assign rx_k     = inj ? b_k     : tx_out_k;

    pkt_crc_engine u0 (
        .clk(clk), .rst(rst),
        .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
        .tx_in_data(tx_in_data), .tx_in_k(tx_in_k),
        .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
        .tx_out_data(tx_out_data), .tx_out_k(tx_out_k),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_k(rx_k),
        .rx_crc_ok(rx_crc_ok), .rx_crc_err(rx_crc_err)
    );

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference CRC: shift in byte bits high first, polynomial 0x04C11DB7
    function automatic logic [31:0] ref_crc(logic [31:0] c, logic [7:0] b);
        logic [31:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[31] != b[i]) r = (r << 1) ^ 32'h04C11DB7;
            else               r = r << 1;
        end
        return r;
    endfunction

    // output ready pattern
    initial forever begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_out_ready = rnd ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // monitor: samples between edges
    initial begin
        logic       pv = 1'b0;
        logic [8:0] ps = '0;
        forever begin
            @(negedge clk);
            #2;
            if (pv && !(tx_out_valid && {tx_out_k, tx_out_data} == ps)) stall_viol++;
            pv = tx_out_valid && !tx_out_ready;
            ps = {tx_out_k, tx_out_data};
            if (!inj && tx_out_valid && tx_out_ready && got_n < 2048) begin
                got_mem[got_n] = {tx_out_k, tx_out_data};
                got_n++;
            end
            if (rx_crc_ok) ok_cnt++;
            if (rx_crc_err) err_cnt++;
            if (rx_crc_ok && rx_crc_err) both_cnt++;
        end
    end

    task automatic push_exp(input logic k, input logic [7:0] d);
        if (exp_n < 2048) exp_mem[exp_n] = {k, d};
        exp_n++;
    endtask

    task automatic send(input logic k, input logic [7:0] d, output int waits);
        @(negedge clk);
        tx_in_valid = 1'b1;
        tx_in_k = k;
        tx_in_data = d;
        waits = 0;
        forever begin
            #2;
            if (tx_in_ready) break;
            waits++;
            @(negedge clk);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        tx_in_valid = 1'b0;
    endtask

    function automatic logic [7:0] pat(int seed, int i);
        return 8'((seed * 37 + i * 11 + i * i) & 255);
    endfunction

    // send one packet; returns the reference CRC
    task automatic tx_pkt(input int len, input int seed, input bit chk_wait);
        int w;
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] f;
        send(1'b1, 8'hFB, w);
        push_exp(1'b1, 8'hFB);
        for (int i = 0; i < len; i++) begin
            logic kk = (i == 3) && seed[0];
            logic [7:0] d = kk ? 8'hBC : pat(seed, i);
            send(kk, d, w);
            push_exp(kk, d);
            c = ref_crc(c, d);
        end
        f = ~c;
        for (int j = 0; j < 4; j++) push_exp(1'b0, f[31 - 8*j -: 8]);
        push_exp(1'b1, 8'hFD);
        send(1'b1, 8'hFD, w);
        if (chk_wait) chk(w == 4, "R4", "end symbol wait cycles", w, 4);
    endtask

    task automatic compare(input string req);
        repeat (10) @(negedge clk);
        chk(got_n == exp_n, req, "output symbol count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n && i < 2048; i++)
            chk(got_mem[i] == exp_mem[i], req, $sformatf("symbol %0d", i),
                int'(got_mem[i]), int'(exp_mem[i]));
        got_n = 0;
        exp_n = 0;
    endtask

    task automatic rx_put(input logic k, input logic [7:0] d);
        @(negedge clk);
        b_valid = 1'b1;
        b_k = k;
        b_data = d;
    endtask

    task automatic rx_end(input string req, input int exp_ok, input int exp_err);
        int o0 = ok_cnt;
        int e0 = err_cnt;
        rx_put(1'b1, 8'hFD);
        @(negedge clk);
        b_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(ok_cnt - o0 == exp_ok, req, "ok pulses", ok_cnt - o0, exp_ok);
        chk(err_cnt - e0 == exp_err, req, "err pulses", err_cnt - e0, exp_err);
    endtask

    task automatic rx_body(input int len, input int seed, input int flip_at);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] f;
        logic [7:0] fr [0:63];
        int n = 0;
        for (int i = 0; i < len; i++) begin
            fr[n] = pat(seed, i);
            c = ref_crc(c, fr[n]);
            n++;
        end
        f = ~c;
        for (int j = 0; j < 4; j++) begin
            fr[n] = f[31 - 8*j -: 8];
            n++;
        end
        if (flip_at >= 0) fr[flip_at] = fr[flip_at] ^ 8'h10;
        for (int i = 0; i < n; i++) rx_put(1'b0, fr[i]);
    endtask

    initial begin
        int w;
        int p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        chk(tx_out_valid == 1'b0, "R1", "reset out valid", tx_out_valid, 0);
        chk(tx_in_ready == 1'b1, "R4", "reset in ready", tx_in_ready, 1);
        chk(rx_crc_ok == 1'b0 && rx_crc_err == 1'b0, "R11", "reset flags",
            {rx_crc_ok, rx_crc_err}, 0);

        // lengths 0..40, output always ready; also loops into receiver
        p = ok_cnt;
        for (int len = 0; len <= 40; len++) tx_pkt(len, len, 1'b1);
        go_idle();
        compare("R3");
        chk(ok_cnt - p == 41, "R8", "loopback ok pulses", ok_cnt - p, 41);

        // same sweep with random backpressure
        rnd = 1'b1;
        p = ok_cnt;
        for (int len = 0; len <= 40; len++) tx_pkt(len, len + 100, 1'b0);
        go_idle();
        compare("R2");
        chk(ok_cnt - p == 41, "R8", "backpressure ok pulses", ok_cnt - p, 41);
        rnd = 1'b0;
        chk(stall_viol == 0, "R5", "output changed while stalled", stall_viol, 0);

        // stray end symbol
        p = ok_cnt + err_cnt;
        send(1'b1, 8'hFD, w);
        push_exp(1'b1, 8'hFD);
        chk(w == 0, "R6", "stray end wait", w, 0);
        go_idle();
        compare("R6");
        chk(ok_cnt + err_cnt == p, "R9", "stray end flags", ok_cnt + err_cnt - p, 0);

        // restart on a second start symbol
        send(1'b1, 8'hFB, w);
        push_exp(1'b1, 8'hFB);
        for (int i = 0; i < 5; i++) begin
            send(1'b0, pat(7, i), w);
            push_exp(1'b0, pat(7, i));
        end
        exp_n = exp_n;
        tx_pkt(9, 42, 1'b1);
        go_idle();
        compare("R7");

        // receiver driven directly
        inj = 1'b1;
        rx_put(1'b1, 8'hFB); rx_body(12, 3, -1); rx_end("R8", 1, 0);
        rx_put(1'b1, 8'hFB); rx_body(12, 3, 5);  rx_end("R8", 0, 1);
        rx_put(1'b1, 8'hFB); rx_body(12, 3, 13); rx_end("R8", 0, 1);
        rx_put(1'b1, 8'hFB); rx_put(1'b0, 8'h11); rx_put(1'b0, 8'h22);
        rx_end("R9", 0, 1);
        rx_end("R9", 0, 0);
        rx_put(1'b1, 8'hFB); rx_body(0, 0, -1); rx_end("R9", 1, 0);
        rx_put(1'b1, 8'hFB); rx_put(1'b0, 8'h5A); rx_put(1'b0, 8'hA5);
        rx_put(1'b1, 8'hFB); rx_body(20, 9, -1); rx_end("R10", 1, 0);
        inj = 1'b0;
        chk(both_cnt == 0, "R11", "both flags high", both_cnt, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule